// File: doc/BRIEF.md
# Semi-Carry-Save Radix-2 Modular Multiplier

This block computes the modular product S = A·B·R⁻¹ mod N for an odd K-bit modulus N, with R = 2^(K+2). The operands and the result are plain binary numbers. A single-cycle `start` strobe loads A, B and N while the block is idle. One cycle with `done` high then reports the result, which stays on `result` until the next accepted start. The caller keeps A and B below N.

Inside, the running partial product is held as a sum word and a carry word, so no carry ripples across the word during the K+2 multiply iterations. One row of full adders does all the arithmetic. Before the loop it resolves B+N into a stored sum D by repeated carry-save passes with a zero third input. In each iteration it adds 0, N, B or D, picked by the multiplier bit and the quotient bit. After the loop it turns the sum/carry pair back into binary by passing the pair through with a zero input until the carry word is empty. Because the loop runs two iterations more than K, the result lies below 2N and no final subtraction is made. The time taken depends on the data, so callers wait for `done`.

Top module: `msc_modmul`

## Requirements
- R1: For odd N ≥ 3 and A, B < N, `result` equals the value S(K+2) of the recurrence S(0)=0, S(i+1) = (S(i) + a_i·B + q_i·N)/2, where a_i is bit i of A (zero for i ≥ K) and q_i = (S(i) + a_i·B) mod 2. Therefore result·2^(K+2) ≡ A·B (mod N).
- R2: At `done`, `result` < 2N, with no final subtraction of N.
- R3: If the start is accepted at clock edge 0, `done` is high after edge P+C+K+4 and at no earlier edge. P is the number of passes (x,y) → (x⊕y, (x∧y)<<1) that take the pair (B,N) to y = 0. C is the number of such passes that take the final sum/carry pair of the loop to a zero carry word.
- R4: `done` is high for exactly one cycle, and `busy` is low in that cycle. While the block stays idle without a start, `result` holds its value.
- R5: `busy` rises in the cycle after a start is accepted in the idle state and stays high until the cycle in which `done` is high.
- R6: A `start` while `busy` is high is ignored. The operation in flight keeps its result and its timing, and no further operation follows it.
- R7: After a synchronous active-low reset, `busy`, `done` and `result` are all zero.
- R8: The extreme operands give correct results and the R3 timing. These are A = 0 (result 0), the smallest modulus N = 3, and the largest modulus N = 2^K−1 with A = B = N−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication; taken only when idle |
| op_a | input | K | Multiplier A, below N |
| op_b | input | K | Multiplicand B, below N |
| modulus | input | K | Odd modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | K+1 | Product A·B·2^-(K+2), congruent mod N and below 2N |

## Verification
The main function is tried with a zero multiplier, unit operands, the smallest modulus, the all-ones modulus with A = B = N−1, and a run of pseudo-random odd moduli with operands spread over their range. A zero multiplier shows whether the quotient bits alone leave the sum at zero. Unit and small-modulus cases expose a wrong operand mapping for (a_i, q_i), because each of the four choices changes the result. The all-ones cases give long carry chains in both the B+N precompute and the final conversion, so an early stop in either loop shows up as a wrong value or a wrong cycle count. The random cases mix every selection pattern, and in some of them a stray start is injected mid-run to show that it is ignored.

// File: rtl/msc_pkg.sv
// Shared types for the semi-carry-save modular multiplier.
// Assumes nothing beyond the enumeration below being used by all modules.
package msc_pkg;

    // Operating phases of the multiplier.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for start
        ST_PRE  = 2'd1,  // resolving D = B + N through the adder row
        ST_MUL  = 2'd2,  // K+2 halving carry-save iterations
        ST_CONV = 2'd3   // flushing the carry word into binary
    } msc_state_e;

endpackage

// File: rtl/msc_csa.sv
// One row of full adders shared by every phase.
// In halving mode the new pair is (sum>>1, majority), which is (SS+SC+X)/2
// whenever SS+SC+X is even. In plain mode the new pair is
// (sum, majority<<1), which keeps SS+SC unchanged when X is zero.
// Assumes the represented value fits in W bits, so the dropped carry MSB is zero.
module msc_csa #(
    parameter int W = 18
) (
    input  logic         halve,
    input  logic [W-1:0] ss_i,
    input  logic [W-1:0] sc_i,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] ss_o,
    output logic [W-1:0] sc_o,
    output logic         lsb_o
);

    logic [W-1:0] bit_sum;
    logic [W-1:0] bit_maj;

    // Full-adder row: bitwise sum and majority of the three inputs.
    always_comb begin
        bit_sum = ss_i ^ sc_i ^ x_i;
        bit_maj = (ss_i & sc_i) | (ss_i & x_i) | (sc_i & x_i);
    end

    // Place the outputs for the selected mode.
    always_comb begin
        if (halve) begin
            ss_o = {1'b0, bit_sum[W-1:1]};
            sc_o = bit_maj;
        end else begin
            ss_o = bit_sum;
            sc_o = {bit_maj[W-2:0], 1'b0};
        end
        lsb_o = ss_o[0] ^ sc_o[0];
    end

endmodule

// File: rtl/msc_opsel.sv
// Four-way operand selector feeding the adder row.
// Code (a,q): 00 -> zero, 01 -> N, 10 -> B, 11 -> D = B+N.
// Assumes all four candidates are already W bits wide.
module msc_opsel #(
    parameter int W = 18
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] opd_n,
    input  logic [W-1:0] opd_b,
    input  logic [W-1:0] opd_d,
    output logic [W-1:0] opd_o
);

    // Pick one operand according to the two-bit code.
    always_comb begin
        unique case (sel)
            2'b00:   opd_o = '0;
            2'b01:   opd_o = opd_n;
            2'b10:   opd_o = opd_b;
            default: opd_o = opd_d;
        endcase
    end

endmodule

// File: rtl/msc_ctrl.sv
// Phase sequencer for the multiplier.
// It leaves the precompute and conversion phases when the datapath reports an
// empty carry word, and counts K+2 multiply iterations.
// Assumes start is sampled only in the idle phase.
module msc_ctrl #(
    parameter int K = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                carry_empty,
    output msc_pkg::msc_state_e phase,
    output logic                busy,
    output logic                done
);
    import msc_pkg::*;

    localparam int ITERS = K + 2;
    localparam int CW    = $clog2(ITERS);
    localparam logic [CW-1:0] LAST_IT = CW'(ITERS - 1);

    msc_state_e    st_q;
    logic [CW-1:0] it_q;
    logic          done_q;

    // Phase register, iteration counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            it_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) st_q <= ST_PRE;
                end
                ST_PRE: begin
                    if (carry_empty) begin
                        st_q <= ST_MUL;
                        it_q <= '0;
                    end
                end
                ST_MUL: begin
                    it_q <= it_q + 1'b1;
                    if (it_q == LAST_IT) st_q <= ST_CONV;
                end
                default: begin
                    if (carry_empty) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Status outputs.
    always_comb begin
        phase = st_q;
        busy  = (st_q != ST_IDLE);
        done  = done_q;
    end

endmodule

// File: rtl/msc_modmul.sv
// Semi-carry-save radix-2 modular multiplier, top level.
// It computes A*B*2^-(K+2) mod N with one shared full-adder row. The adder row
// resolves B+N first, then runs K+2 halving iterations, then converts the
// sum/carry pair to binary. The operand bit and quotient bit for each iteration
// are registered one cycle ahead.
// Assumes N is odd and A, B < N. The result is below 2N.
module msc_modmul #(
    parameter int K = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    input  logic [K-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic [K:0]   result
);
    import msc_pkg::*;

    localparam int W = K + 2;

    msc_state_e   phase;
    logic [W-1:0] ss_q, sc_q, d_q, a_sh_q;
    logic [K-1:0] b_q, n_q;
    logic         ai_q, qi_q;
    logic         carry_empty;
    logic [W-1:0] opd, ss_nx, sc_nx;
    logic         lsb_nx;
    logic [1:0]   sel;
    logic         mul_mode;

    // An empty carry word ends both the precompute and the conversion.
    always_comb begin
        carry_empty = (sc_q == '0);
        mul_mode    = (phase == ST_MUL);
        sel         = mul_mode ? {ai_q, qi_q} : 2'b00;
    end

    msc_ctrl #(.K(K)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .carry_empty (carry_empty),
        .phase       (phase),
        .busy        (busy),
        .done        (done)
    );

    msc_opsel #(.W(W)) u_opsel (
        .sel   (sel),
        .opd_n ({2'b00, n_q}),
        .opd_b ({2'b00, b_q}),
        .opd_d (d_q),
        .opd_o (opd)
    );

    msc_csa #(.W(W)) u_csa (
        .halve (mul_mode),
        .ss_i  (ss_q),
        .sc_i  (sc_q),
        .x_i   (opd),
        .ss_o  (ss_nx),
        .sc_o  (sc_nx),
        .lsb_o (lsb_nx)
    );

    // Datapath registers, advanced according to the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q   <= '0;
            sc_q   <= '0;
            d_q    <= '0;
            a_sh_q <= '0;
            b_q    <= '0;
            n_q    <= '0;
            ai_q   <= 1'b0;
            qi_q   <= 1'b0;
        end else begin
            unique case (phase)
                ST_IDLE: begin
                    if (start) begin
                        ss_q   <= {2'b00, op_b};
                        sc_q   <= {2'b00, modulus};
                        a_sh_q <= {2'b00, op_a};
                        b_q    <= op_b;
                        n_q    <= modulus;
                    end
                end
                ST_PRE: begin
                    if (carry_empty) begin
                        d_q  <= ss_q;
                        ss_q <= '0;
                        sc_q <= '0;
                        ai_q <= a_sh_q[0];
                        qi_q <= a_sh_q[0] & b_q[0];
                    end else begin
                        ss_q <= ss_nx;
                        sc_q <= sc_nx;
                    end
                end
                ST_MUL: begin
                    ss_q   <= ss_nx;
                    sc_q   <= sc_nx;
                    a_sh_q <= {1'b0, a_sh_q[W-1:1]};
                    ai_q   <= a_sh_q[1];
                    qi_q   <= lsb_nx ^ (a_sh_q[1] & b_q[0]);
                end
                default: begin
                    if (!carry_empty) begin
                        ss_q <= ss_nx;
                        sc_q <= sc_nx;
                    end
                end
            endcase
        end
    end

    // Binary result is the low K+1 bits of the resolved sum word.
    always_comb begin
        result = ss_q[K:0];
    end

endmodule

// File: rtl/msc_modmul_chk.sv
// Property checker for msc_modmul, attached by bind.
// Assumes it is bound into msc_modmul and sees its modulus and carry registers.
module msc_modmul_chk #(
    parameter int K = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [K:0]     result,
    input logic [K-1:0]   n_q,
    input logic [K+1:0]   sc_q
);

    // R2: the reported value stays below twice the modulus.
    p_below_2n_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < ({1'b0, n_q} + {1'b0, n_q})));

    // R3: completion is reported only with an empty carry word.
    p_carry_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sc_q == '0));

    // R4: done is a single-cycle pulse.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done coincides with the idle state.
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: result holds while idle with no start.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));

    // R5: an accepted start raises busy in the next cycle.
    p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R6: operands latched for the running operation are not reloaded.
    p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(n_q));

    // R7: reset returns the block to idle with no done.
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == '0));

endmodule

bind msc_modmul msc_modmul_chk #(.K(K)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .n_q    (n_q),
    .sc_q   (sc_q)
);

// File: tb/msc_modmul_bench.sv
// Self-checking bench for msc_modmul with a behavioural integer model.
module msc_modmul_bench;

    localparam int K = 16;
    localparam int W = K + 2;
    localparam longint unsigned WMASK = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [K-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic         busy, done;
    logic [K:0]   result;

    int compared = 0;
    int mismatched = 0;
    int unsigned seed = 32'h1234_5678;

    msc_modmul #(.K(K)) u_msc_modmul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .modulus(modulus), .busy(busy), .done(done), .result(result)
    );

    always #4 clk = ~clk;

    // Record one comparison.
    task automatic chk(input bit ok, input string tag,
                       input longint unsigned act, input longint unsigned exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Exact radix-2 recurrence on integers (R1).
    function automatic longint unsigned ref_value(longint unsigned a, longint unsigned b,
                                                  longint unsigned n);
        longint unsigned s = 0;
        for (int i = 0; i < K + 2; i++) begin
            longint unsigned t = s + (((a >> i) & 1) * b);
            s = (t + ((t & 1) * n)) >> 1;
        end
        return s;
    endfunction

    // Passes of x,y -> x^y,(x&y)<<1 until y is zero (R3).
    function automatic int passes(longint unsigned x, longint unsigned y);
        int p = 0;
        while (y != 0) begin
            longint unsigned t = x ^ y;
            y = ((x & y) << 1) & WMASK;
            x = t;
            p++;
        end
        return p;
    endfunction

    // Conversion pass count for the pair the loop leaves behind (R3).
    function automatic int conv_passes(longint unsigned a, longint unsigned b,
                                       longint unsigned n);
        longint unsigned ss = 0, sc = 0, d = b + n;
        for (int i = 0; i < K + 2; i++) begin
            longint unsigned ai = (a >> i) & 1;
            longint unsigned qi = ((ss ^ sc) & 1) ^ (ai & b & 1);
            longint unsigned x = (ai != 0) ? ((qi != 0) ? d : b) : ((qi != 0) ? n : 0);
            longint unsigned s = ss ^ sc ^ x;
            longint unsigned c = (ss & sc) | (ss & x) | (sc & x);
            ss = s >> 1;
            sc = c & WMASK;
        end
        return passes(ss, sc);
    endfunction

    // One multiplication, checked on every clock; poke injects a stray start.
    task automatic run_op(input longint unsigned a, input longint unsigned b,
                          input longint unsigned n, input bit poke);
        longint unsigned exp_s = ref_value(a, b, n);
        int lat = passes(b, n) + conv_passes(a, b, n) + K + 4;
        @(negedge clk);
        op_a = K'(a); op_b = K'(b); modulus = K'(n); start = 1'b1;
        for (int m = 0; m <= lat + 3; m++) begin
            @(negedge clk);
            if (m == 0) start = 1'b0;
            chk(busy == (m < lat), "R5 busy", longint'(busy), longint'(m < lat));
            chk(done == (m == lat), "R3 done timing", longint'(done), longint'(m == lat));
            if (m == lat) begin
                chk(longint'(result) == exp_s, "R1 value", longint'(result), exp_s);
                chk(((longint'(result) << (K + 2)) % n) == ((a * b) % n), "R1 congruence",
                    (longint'(result) << (K + 2)) % n, (a * b) % n);
                chk(longint'(result) < 2 * n, "R2 below 2N", longint'(result), 2 * n);
            end
            if (m > lat)
                chk(longint'(result) == exp_s, "R4 hold after done", longint'(result), exp_s);
            if (poke && m == 3) begin
                // R6: stray start with other operands while busy
                op_a = ~op_a; op_b = '1; modulus = 16'h0003; start = 1'b1;
            end
            if (poke && m == 4) start = 1'b0;
        end
    endtask

    function automatic int unsigned lcg();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R7 reset busy", longint'(busy), 0);
        chk(done == 1'b0, "R7 reset done", longint'(done), 0);
        chk(result == '0, "R7 reset result", longint'(result), 0);

        run_op(0, 12345, 40961, 1'b0);          // R8 zero multiplier
        run_op(1, 1, 40961, 1'b0);              // R1 unit operands
        run_op(2, 1, 3, 1'b0);                  // R8 smallest modulus
        run_op(1, 2, 3, 1'b0);                  // R8 smallest modulus, swapped
        run_op(65534, 65534, 65535, 1'b0);      // R8 all-ones modulus
        run_op(65534, 1, 65535, 1'b1);          // R6 stray start during run
        run_op(32767, 32768, 65535, 1'b0);      // R1 long carry chains

        for (int t = 0; t < 24; t++) begin
            longint unsigned n = longint'((lcg() & 32'hFFFF) | 32'h1);
            longint unsigned a, b;
            if (n < 3) n = 3;
            a = longint'(lcg()) % n;
            b = longint'(lcg()) % n;
            run_op(a, b, n, (t % 4) == 1);      // R1 R2 R3 R6 random patterns
        end

        // R4: no further done while idle
        repeat (5) begin
            @(negedge clk);
            chk(done == 1'b0, "R4 idle no done", longint'(done), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule